// File: doc/BRIEF.md
# Dual-Strobe Load/Shift Register

This block is a small register, four bits wide by default, with one serial input, one parallel input word and one mode-select input. Two separate strobe inputs trigger its operations. A high-to-low transition on the shift strobe moves the contents one place toward the last stage. A high-to-low transition on the load strobe copies the parallel word into the register. The mode input decides which of the two strobes is obeyed, and the other strobe is ignored.

The strobes and the mode input are treated as asynchronous levels. Each passes through its own synchronizer into one system-clock domain. A falling edge is found by comparing the synchronized sample with the one from the cycle before. The mode value used for an operation is the synchronized value in the cycle where the edge is found. Because of this, toggling the mode input can never change the stored bits.

A shift toward the first stage needs no extra logic. Each output is wired back to the parallel input one place closer to the first stage, serial data is applied at the last parallel input, and the register is clocked with the load strobe in load mode. Both strobes may also be tied to a single source, and the mode input then picks the operation.

Top module: `lsreg_dual_strobe`

## Requirements
- R1: While rst_n is low at a rising clk edge, q_o becomes all zeros.
- R2: With mode_i high (load mode), a falling edge on load_stb_i sets q_o[i] to par_i[i] for every i. Bit 0 is the first stage.
- R3: With mode_i low (shift mode), a falling edge on shift_stb_i makes q_o[0] take ser_i and q_o[i] take the old q_o[i-1] for i from 1 to WIDTH-1.
- R4: A falling edge on shift_stb_i while mode_i is high leaves q_o unchanged, so no serial data enters in load mode.
- R5: A falling edge on load_stb_i while mode_i is low leaves q_o unchanged.
- R6: Changing mode_i while neither strobe falls leaves q_o unchanged, whatever level each strobe is held at.
- R7: Rising edges on either strobe leave q_o unchanged.
- R8: With both strobes driven from one source, each falling edge performs the load when mode_i is high and the right shift when mode_i is low.
- R9: With SYNC_STAGES=2, q_o shows the new value after the third rising clk edge following a strobe fall, and not after the second. The strobe and mode_i must have been steady for at least three cycles before that fall.
- R10: Wiring par_i[i] to q_o[i+1] for i below WIDTH-1, with serial data on par_i[WIDTH-1], and then loading shifts the contents toward bit 0. Bit 0 takes the old bit 1 and the top bit takes the serial data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_stb_i | input | 1 | Asynchronous strobe; its falling edge shifts in shift mode |
| load_stb_i | input | 1 | Asynchronous strobe; its falling edge loads in load mode |
| mode_i | input | 1 | 1 selects load mode, 0 selects shift mode (asynchronous) |
| ser_i | input | 1 | Serial data for the right shift |
| par_i | input | WIDTH | Parallel load word; bit 0 feeds the first stage |
| q_o | output | WIDTH | Register contents; bit 0 is the first stage |

## Verification
Random operations mix every combination of mode, strobe choice and serial and parallel data. This separates a correct mode gate from one that obeys the wrong strobe or leaks serial data into a load. Some operations toggle the mode while the strobes are held high or low. These show whether a mode change alone, or a rising strobe, can disturb the contents. Directed shifts of all ones and all zeros, a shift-left run through the external feedback, tied strobes and a cycle-exact latency probe catch errors in bit order, edge polarity and synchronizer depth.

// File: rtl/lsreg_pkg.sv
package lsreg_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_SHIFT = 2'd1,
      OP_LOAD  = 2'd2
   } lsreg_op_e;
endpackage

// File: rtl/lsreg_sync.sv
module lsreg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial begin
      if (STAGES < 2) $error("lsreg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lsreg_fall_det.sv
module lsreg_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic s_i,
   output logic fall_o
);
   logic prev;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= s_i;
   end

   assign fall_o = prev & ~s_i;
endmodule

// File: rtl/lsreg_core.sv
module lsreg_core
   import lsreg_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lsreg_op_e        op_i,
   input  logic             ser_i,
   input  logic [WIDTH-1:0] par_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] q_r;
   logic [WIDTH-1:0] shifted;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign shifted[i] = ser_i;
         end else begin : g_body
            assign shifted[i] = q_r[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r <= '0;
      end else begin
         case (op_i)
            OP_SHIFT: q_r <= shifted;
            OP_LOAD:  q_r <= par_i;
            default:  q_r <= q_r;
         endcase
      end
   end

   assign q_o = q_r;
endmodule

// File: rtl/lsreg_dual_strobe.sv
module lsreg_dual_strobe
   import lsreg_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_stb_i,
   input  logic             load_stb_i,
   input  logic             mode_i,
   input  logic             ser_i,
   input  logic [WIDTH-1:0] par_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      if (WIDTH < 2)       $error("lsreg_dual_strobe: WIDTH must be at least 2");
      if (SYNC_STAGES < 2) $error("lsreg_dual_strobe: SYNC_STAGES must be at least 2");
   end

   logic shift_s, load_s, mode_s;
   logic shift_fall, load_fall;
   lsreg_op_e op;

   lsreg_sync #(.STAGES(SYNC_STAGES)) u_sync_shift (
      .clk(clk), .rst_n(rst_n), .d_i(shift_stb_i), .q_o(shift_s));
   lsreg_sync #(.STAGES(SYNC_STAGES)) u_sync_load (
      .clk(clk), .rst_n(rst_n), .d_i(load_stb_i), .q_o(load_s));
   lsreg_sync #(.STAGES(SYNC_STAGES)) u_sync_mode (
      .clk(clk), .rst_n(rst_n), .d_i(mode_i), .q_o(mode_s));

   lsreg_fall_det u_fall_shift (
      .clk(clk), .rst_n(rst_n), .s_i(shift_s), .fall_o(shift_fall));
   lsreg_fall_det u_fall_load (
      .clk(clk), .rst_n(rst_n), .s_i(load_s), .fall_o(load_fall));

   always_comb begin
      op = OP_HOLD;
      if (mode_s) begin
         if (load_fall) op = OP_LOAD;
      end else begin
         if (shift_fall) op = OP_SHIFT;
      end
   end

   lsreg_core #(.WIDTH(WIDTH)) u_core (
      .clk(clk), .rst_n(rst_n), .op_i(op), .ser_i(ser_i),
      .par_i(par_i), .q_o(q_o));
endmodule

// File: rtl/lsreg_dual_strobe_chk.sv
module lsreg_dual_strobe_chk
   import lsreg_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ser_i,
   input logic [WIDTH-1:0] par_i,
   input logic [WIDTH-1:0] q_o,
   input logic             mode_s,
   input logic             shift_fall,
   input logic             load_fall,
   input lsreg_op_e        op
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) !rst_n |=> q_o == '0);

   // R2
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_fall && mode_s) |=> q_o == $past(par_i));

   // R3
   shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_fall && !mode_s) |=> q_o == {$past(q_o[WIDTH-2:0]), $past(ser_i)});

   // R4
   shift_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_fall && mode_s && !load_fall) |=> $stable(q_o));

   // R5
   load_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_fall && !mode_s && !shift_fall) |=> $stable(q_o));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_fall && !load_fall) |=> $stable(q_o));
endmodule

bind lsreg_dual_strobe lsreg_dual_strobe_chk #(.WIDTH(WIDTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .ser_i(ser_i), .par_i(par_i), .q_o(q_o),
   .mode_s(mode_s), .shift_fall(shift_fall), .load_fall(load_fall), .op(op));

// File: tb/lsreg_dual_strobe_tb_top.sv
`timescale 1ns/1ps
module lsreg_dual_strobe_tb_top;
   localparam int W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shift_stb = 1'b0, load_stb = 1'b0, mode = 1'b0, ser = 1'b0;
   logic [W-1:0] par = '0;
   logic [W-1:0] q;
   logic [W-1:0] exp_q = '0;
   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lsreg_dual_strobe #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .shift_stb_i(shift_stb), .load_stb_i(load_stb),
      .mode_i(mode), .ser_i(ser), .par_i(par), .q_o(q));

   function automatic logic [W-1:0] model(input logic [W-1:0] cur, input bit sh,
                                          input bit ld, input bit m, input bit s,
                                          input logic [W-1:0] p);
      if (m && ld)       return p;
      else if (!m && sh) return {cur[W-2:0], s};
      else               return cur;
   endfunction

   task automatic check(input string tag);
      n_vec++;
      if (q !== exp_q) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, q, exp_q);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // raise the chosen strobes, optionally toggle mode while high, then drop them
   task automatic op(input bit m, input bit sh, input bit ld, input int ntog,
                     input bit s, input logic [W-1:0] p, input string tag);
      mode = m; ser = s; par = p;
      wait_n(4);
      shift_stb = sh; load_stb = ld;
      wait_n(5);
      check({tag, " R7 rising edge"});
      for (int t = 0; t < ntog; t++) begin
         mode = ~mode;
         wait_n(4);
         check({tag, " R6 mode toggle"});
      end
      wait_n(1);
      exp_q = model(exp_q, sh, ld, mode, s, p);
      shift_stb = 1'b0; load_stb = 1'b0;
      wait_n(5);
      check(tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      wait_n(3);
      check("R1 reset");
      rst_n = 1'b1;
      wait_n(2);
      // R2 directed load
      op(1'b1, 1'b0, 1'b1, 0, 1'b0, 4'b1010, "R2 load");
      // R3 shift ones then zeros
      for (int i = 0; i < 5; i++) op(1'b0, 1'b1, 1'b0, 0, 1'b1, 4'b0000, "R3 shift ones");
      for (int i = 0; i < 5; i++) op(1'b0, 1'b1, 1'b0, 0, 1'b0, 4'b1111, "R3 shift zeros");
      op(1'b1, 1'b0, 1'b1, 0, 1'b0, 4'b0110, "R2 load");
      // R4 shift strobe in load mode
      op(1'b1, 1'b1, 1'b0, 0, 1'b1, 4'b1111, "R4 wrong-mode shift");
      // R5 load strobe in shift mode
      op(1'b0, 1'b0, 1'b1, 0, 1'b1, 4'b1001, "R5 wrong-mode load");
      // R6 mode toggling with both strobes low
      for (int t = 0; t < 4; t++) begin
         mode = ~mode;
         wait_n(4);
         check("R6 toggle strobes low");
      end
      // R8 tied strobes
      op(1'b1, 1'b1, 1'b1, 0, 1'b0, 4'b0011, "R8 common load");
      op(1'b0, 1'b1, 1'b1, 0, 1'b1, 4'b1100, "R8 common shift");
      // R10 shift-left through external wiring
      for (int i = 0; i < 6; i++) begin
         bit s = 1'((i % 3) == 0);
         op(1'b1, 1'b0, 1'b1, 0, 1'b0, {s, exp_q[W-1:1]}, "R10 shift left");
      end
      // R9 latency probe
      mode = 1'b1; par = 4'b0101;
      wait_n(4);
      load_stb = 1'b1;
      wait_n(5);
      load_stb = 1'b0;
      wait_n(2);
      check("R9 before third edge");
      exp_q = 4'b0101;
      wait_n(1);
      check("R9 after third edge");
      // random mix
      for (int k = 0; k < 250; k++) begin
         op(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 3),
            1'($urandom), W'($urandom), "R2/R3/R4/R5 random");
      end
      // R1 reset mid-run
      rst_n = 1'b0;
      exp_q = '0;
      wait_n(2);
      check("R1 reset again");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(20ns * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule